// File: doc/BRIEF.md
# Edge-Triggered Wake-Up Interrupt Port

This block watches an eight-bit group of input pins. For each pin, software chooses whether a rising or a falling transition counts as an event, and whether that pin may record events at all. A qualifying transition on an allowed pin sets that pin's bit in a sticky pending register. The bit stays set until software clears it by writing a one to it. The pending bits drive two outputs. The first is a maskable interrupt request, which also needs a port-level enable and the global interrupt enable. The second is a wake request, which ends a low-power halt or idle state whether or not the interrupt path is enabled.

Each pin is brought into the clock domain by a two-flop synchronizer. A transition is found by comparing the synchronized level with the level one clock earlier. Registers are reached through a small port: a write strobe with a two-bit select and eight data bits, and a two-bit read select whose data comes back one clock later. There is no separate summary pending flag. The pending register itself is the only record of events.

Top module: `edge_wake_port`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, the enable, polarity and pending registers are all zero, and `irq_o` and `wake_o` are low.
- R2: Register selects are: 0 = pin enable, 1 = edge polarity, 2 = pending, 3 = unused (reads 0). Bit i of each register belongs to pin i. A read returns the selected register on `rd_data_o` one clock after `rd_sel_i` is applied. Writes to selects 0 and 1 load the data.
- R3: With polarity bit i = 0, a low-to-high change on pin i sets pending bit i when enable bit i is 1. A high-to-low change does not.
- R4: With polarity bit i = 1, a high-to-low change on pin i sets pending bit i when enable bit i is 1. A low-to-high change does not.
- R5: A pin whose enable bit is 0 never sets its pending bit, in either direction.
- R6: A pending bit stays set until a write to select 2 has a 1 in that bit position. Zeros in the written data leave pending bits unchanged.
- R7: If a qualifying edge reaches the pending register in the same clock as a clearing write to that bit, the bit ends up set.
- R8: `irq_o` is high exactly when `port_irq_en_i` and `glob_irq_en_i` are both high and some pending bit with its enable bit set is 1. The output is registered, so it reflects the previous clock's inputs.
- R9: `wake_o` is high exactly when `sleep_i` is high and any pending bit is 1, independent of both interrupt enables. The output is registered one clock.
- R10: Writing a polarity bit while its pin is steady never sets a pending bit.
- R11: A pin change made before a clock edge is visible in the pending register after the third rising clock edge. It is readable on `rd_data_o` one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous port pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 8 | Write data (write-1-to-clear for pending) |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 8 | Registered read data |
| port_irq_en_i | input | 1 | Port-level interrupt enable |
| glob_irq_en_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Device is in halt or idle state |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | Registered wake request |

## Verification
The hardest case to produce from the ports is a pin edge landing in the pending register in the same clock as a clearing write. The synchronizer hides the exact cycle, so the bench counts edges. It changes the pin just after a falling clock edge, lets two rising edges pass, and then raises the clear strobe for exactly the third edge. In that test another pending bit that sees no edge is cleared by the same write. This shows that the clear did take effect and that only the racing bit survived. The rest of the bench sweeps every pin in both directions under both polarities, and sweeps all eight combinations of the two enables and the sleep input.

// File: rtl/ewp_pkg.sv
package ewp_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_POLARITY = 2'd1,
    SEL_PENDING = 2'd2,
    SEL_NONE    = 2'd3
  } ewp_sel_e;
endpackage

// File: rtl/ewp_sync.sv
module ewp_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, stab_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
      last_q <= stab_q;
    end
  end

  assign cur_o  = stab_q;
  assign prev_o = last_q;
endmodule

// File: rtl/ewp_edge.sv
module ewp_edge #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] fall_sel_i,
  output logic [WIDTH-1:0] hit_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic rise, fall;
    always_comb begin
      rise = cur_i[g] & ~prev_i[g];
      fall = ~cur_i[g] & prev_i[g];
      hit_o[g] = en_i[g] & (fall_sel_i[g] ? fall : rise);
    end
  end
endmodule

// File: rtl/ewp_pend.sv
module ewp_pend #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hit_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | hit_i;
  end

  assign pend_o = pend_q;

  // R6: a bit only drops after a clear request for it
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0));

  // R7: an edge always leaves its bit set, clear or not
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|hit_i) |=> ((pend_q & $past(hit_i)) == $past(hit_i)));
endmodule

// File: rtl/edge_wake_port.sv
module edge_wake_port #(
  parameter int NPINS = 8,
  parameter int SELW  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en_i,
  input  logic [SELW-1:0]  wr_sel_i,
  input  logic [NPINS-1:0] wr_data_i,
  input  logic [SELW-1:0]  rd_sel_i,
  output logic [NPINS-1:0] rd_data_o,
  input  logic             port_irq_en_i,
  input  logic             glob_irq_en_i,
  input  logic             sleep_i,
  output logic             irq_o,
  output logic             wake_o
);
  import ewp_pkg::*;

  logic [NPINS-1:0] en_q, fall_q, cur, prev, hit, clr, pend;

  ewp_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  ewp_edge #(.WIDTH(NPINS)) u_edge (
    .cur_i(cur), .prev_i(prev), .en_i(en_q), .fall_sel_i(fall_q), .hit_o(hit)
  );

  assign clr = (wr_en_i && wr_sel_i == SEL_PENDING) ? wr_data_i : '0;

  ewp_pend #(.WIDTH(NPINS)) u_pend (
    .clk(clk), .rst(rst), .hit_i(hit), .clr_i(clr), .pend_o(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      fall_q    <= '0;
      rd_data_o <= '0;
      irq_o     <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_ENABLE)   en_q   <= wr_data_i;
      if (wr_en_i && wr_sel_i == SEL_POLARITY) fall_q <= wr_data_i;
      case (rd_sel_i)
        SEL_ENABLE:   rd_data_o <= en_q;
        SEL_POLARITY: rd_data_o <= fall_q;
        SEL_PENDING:  rd_data_o <= pend;
        default:      rd_data_o <= '0;
      endcase
      irq_o  <= port_irq_en_i & glob_irq_en_i & (|(pend & en_q));
      wake_o <= sleep_i & (|pend);
    end
  end

  // R5: disabled pins never gain a pending bit
  a_r5_no_pend_disabled: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((pend & ~$past(pend) & ~$past(en_q)) == '0));

  // R8: interrupt only with both enables present the cycle before
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(port_irq_en_i && glob_irq_en_i));

  // R9: sleeping with a pending bit always wakes
  a_r9_wake: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && (|pend)) |=> wake_o);

  // R9: no wake without a pending bit
  a_r9_no_wake: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(|pend));
endmodule

// File: tb/edge_wake_port_tb.sv
module edge_wake_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       pien = 1'b0, gien = 1'b0, sleep = 1'b0;
  logic       irq, wake;
  int         n_tests = 0, n_fail = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  edge_wake_port u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .port_irq_en_i(pien), .glob_irq_en_i(gien), .sleep_i(sleep),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); rd_sel = sel;
    @(negedge clk); d = rd_data;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, expv;
    repeat (3) @(negedge clk);
    chk(irq == 0 && wake == 0 && rd_data == 0, "R1 outputs in reset", {irq, wake}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(irq == 0 && wake == 0, "R1 outputs after reset", {irq, wake}, 0);
    rd(2'd0, v); chk(v == 0, "R1 enable reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 polarity reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 pending reset", v, 0);

    // R2 register access
    wr(2'd0, 8'h5A); rd(2'd0, v); chk(v == 8'h5A, "R2 enable readback", v, 8'h5A);
    wr(2'd1, 8'hC3); rd(2'd1, v); chk(v == 8'hC3, "R2 polarity readback", v, 8'hC3);
    rd(2'd3, v); chk(v == 0, "R2 unused select", v, 0);

    // R3/R4/R5 sweep: every pin, both polarities, both directions, enabled or not
    for (int en = 0; en < 2; en++)
      for (int i = 0; i < 8; i++)
        for (int p = 0; p < 2; p++)
          for (int d = 0; d < 2; d++) begin
            wr(2'd0, 8'h00);
            @(negedge clk); pin = d ? 8'h00 : 8'hFF;
            settle();
            wr(2'd1, p ? 8'hFF : 8'h00);
            wr(2'd0, en ? (8'h01 << i) : 8'h00);
            wr(2'd2, 8'hFF);
            @(negedge clk); pin[i] = d[0];
            settle();
            rd(2'd2, v);
            expv = (en == 1 && ((d == 1 && p == 0) || (d == 0 && p == 1))) ? (8'h01 << i) : 8'h00;
            chk(v == expv, en == 0 ? "R5 disabled pin" : (p == 0 ? "R3 rising polarity" : "R4 falling polarity"), v, expv);
          end

    // R6 sticky + partial clear
    wr(2'd0, 8'h00); @(negedge clk); pin = 8'h00; settle();
    wr(2'd1, 8'h00); wr(2'd0, 8'hFF); wr(2'd2, 8'hFF);
    @(negedge clk); pin = 8'h0F; settle();
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk(v == 8'h0F, "R6 bits held", v, 8'h0F);
    wr(2'd2, 8'h05); rd(2'd2, v); chk(v == 8'h0A, "R6 write-1 clears only ones", v, 8'h0A);

    // R8/R9 sweep over enables and sleep, pending nonzero then zero
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); pien = k[0]; gien = k[1]; sleep = k[2];
      if (k == 8) wr(2'd2, 8'hFF);
      repeat (2) @(negedge clk);
      chk(irq == (k < 8 && k[0] && k[1]), "R8 irq gating", irq, (k < 8 && k[0] && k[1]));
      chk(wake == (k < 8 && k[2]), "R9 wake", wake, (k < 8 && k[2]));
    end
    pien = 0; gien = 0; sleep = 0;

    // R8: pending bit whose enable was later cleared gives no irq
    @(negedge clk); pin = 8'h00; settle();
    wr(2'd2, 8'hFF);
    @(negedge clk); pin = 8'h01; settle();
    wr(2'd0, 8'hFE);
    @(negedge clk); pien = 1; gien = 1; repeat (2) @(negedge clk);
    chk(irq == 0, "R8 masked-out pending bit", irq, 0);
    @(negedge clk); sleep = 1; repeat (2) @(negedge clk);
    chk(wake == 1, "R9 wake despite mask", wake, 1);
    pien = 0; gien = 0; sleep = 0;

    // R10 polarity flips on steady pins
    wr(2'd0, 8'hFF); @(negedge clk); pin = 8'hA5; settle(); wr(2'd2, 8'hFF);
    for (int j = 0; j < 8; j++) wr(2'd1, 8'h01 << j);
    wr(2'd1, 8'hFF); wr(2'd1, 8'h00);
    settle(); rd(2'd2, v); chk(v == 0, "R10 no false event", v, 0);

    // R11 latency: change just after negedge, count rising edges
    wr(2'd1, 8'h00); @(negedge clk); pin = 8'h00; settle(); wr(2'd2, 8'hFF);
    @(negedge clk); pin = 8'h10; rd_sel = 2'd2;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk(rd_data == 0, "R11 not yet visible", rd_data, 0);
    @(negedge clk);
    chk(rd_data == 8'h10, "R11 visible on read", rd_data, 8'h10);

    // R7 edge and clear in the same clock; bit 4 already set, bit 6 toggled to set first
    @(negedge clk); pin = 8'h50; settle();
    rd(2'd2, v); chk(v == 8'h50, "R7 setup", v, 8'h50);
    @(negedge clk); pin = 8'h10; settle();
    @(negedge clk); pin = 8'h50;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'hFF;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd2, v); chk(v == 8'h40, "R7 set beats clear", v, 8'h40);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule